// File: doc/BRIEF.md
# Dual-Path Priority Interrupt Arbiter

This block picks one winning interrupt line for each of two delivery paths: a normal path and a fast path. It takes pending, mask and path-steering bits and a priority value for every line, in one to three banks of 32 lines each. For each path it drives a request and a registered winner code. A register-file wrapper around the block decodes software accesses, senses the inputs and applies acknowledge side effects. That wrapper sees one clean global-enable level and one re-arm strobe per path.

Each path keeps an armed flag. When the flag is set, the enable is on and the path has at least one candidate, the path raises its request on the next clock edge, stores the winning line's code and clears its armed flag. The request and the code then stay frozen until software pulses that path's re-arm strobe. The strobe drops the request and evaluates the path again in the same cycle. The winner is chosen by a combinational comparison tree over all lines. Lower priority values win, and a tie goes to the line with the larger global index.

Top module: `dual_path_irq_arbiter`

## Requirements
- R1: A line is a candidate for a path only when its pending bit is 1, its mask bit is 0 and its steering bit selects that path (steering 1 = fast path, 0 = normal path). A line that is not a candidate never becomes that path's winner.
- R2: Among candidates, the line with the numerically smallest priority value wins. Value 0 is the most urgent.
- R3: Among candidates with equal priority, the line with the larger global index wins, including between lines in different banks.
- R4: The winner code equals 32 × bank + bit position, where bank 0 holds global lines 0..31. With no candidate the tree's code is 0.
- R5: Once a path has latched a winner, its request and code hold steady and do not follow new or higher-priority candidates until that path is re-armed.
- R6: While the global enable is 0, no path raises its request, even if it is armed and has candidates.
- R7: A re-arm strobe on a path with no candidate (or with the enable off) drives that path's request low on the next edge and leaves its code unchanged.
- R8: A re-arm strobe in the same cycle as a qualifying candidate keeps the request high and loads the new winner code on the next edge.
- R9: After reset both requests are 0, both codes are 0 and both paths are armed.
- R10: A request rises and a code loads on the first clock edge at which the armed flag, a candidate and the enable are present together, and at no other time.
- R11: The two paths are independent: one path's re-arm strobe and candidates do not change the other path's request or code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| pend_i | input | 32×NUM_BANKS | Per-line pending bits, bit n = global line n |
| mask_i | input | 32×NUM_BANKS | Per-line mask bits, 1 = masked |
| steer_i | input | 32×NUM_BANKS | Per-line path select, 1 = fast, 0 = normal |
| prio_i | input | 32×NUM_BANKS×PRIO_W | Priority of line n in bits [n×PRIO_W +: PRIO_W] |
| gen_en_i | input | 1 | Global enable for request generation |
| rearm_norm_i | input | 1 | One-cycle re-arm strobe, normal path |
| rearm_fast_i | input | 1 | One-cycle re-arm strobe, fast path |
| req_norm_o | output | 1 | Normal-path request |
| req_fast_o | output | 1 | Fast-path request |
| code_norm_o | output | clog2(32×NUM_BANKS) | Latched normal-path winner code |
| code_fast_o | output | clog2(32×NUM_BANKS) | Latched fast-path winner code |

## Verification
The main collision is a re-arm strobe that lands in the same cycle as a qualifying candidate. The path must drop and re-raise its request in a single step, so the bench sees the request stay high while the code moves to the new winner. A re-arm with no candidate is set against it, where the request must fall and the code must hold. The bench also re-arms one path while the other is latched and while candidates change, and it toggles the enable around a pending re-arm. A behavioural model scans every line on each clock and judges the requests and codes of both paths.

// File: rtl/arb_pkg.sv
package arb_pkg;
   localparam int LINES_PER_BANK = 32;
   localparam int MAX_BANKS      = 3;

   typedef enum logic {
      PATH_NORM = 1'b0,
      PATH_FAST = 1'b1
   } path_e;
endpackage

// File: rtl/arb_cand_sel.sv
module arb_cand_sel #(
   parameter int            NUM_LINES = 32,
   parameter arb_pkg::path_e PATH     = arb_pkg::PATH_NORM
) (
   input  logic [NUM_LINES-1:0] pend_i,
   input  logic [NUM_LINES-1:0] mask_i,
   input  logic [NUM_LINES-1:0] steer_i,
   output logic [NUM_LINES-1:0] cand_o
);
   logic [NUM_LINES-1:0] route;

   generate
      if (PATH == arb_pkg::PATH_FAST) begin : g_fast
         assign route = steer_i;
      end else begin : g_norm
         assign route = ~steer_i;
      end
   endgenerate

   assign cand_o = pend_i & ~mask_i & route;
endmodule

// File: rtl/arb_prio_tree.sv
module arb_prio_tree #(
   parameter int NUM_LINES = 32,
   parameter int PRIO_W    = 5
) (
   input  logic [NUM_LINES-1:0]        valid_i,
   input  logic [NUM_LINES*PRIO_W-1:0] prio_i,
   output logic                        any_o,
   output logic [$clog2(NUM_LINES)-1:0] idx_o
);
   localparam int IDX_W  = $clog2(NUM_LINES);
   localparam int LEAVES = 1 << IDX_W;
   localparam int NODES  = 2 * LEAVES - 1;

   logic              nv  [NODES];
   logic [PRIO_W-1:0] npr [NODES];
   logic [IDX_W-1:0]  nix [NODES];

   generate
      for (genvar i = 0; i < LEAVES; i++) begin : g_leaf
         if (i < NUM_LINES) begin : g_real
            assign nv[LEAVES-1+i]  = valid_i[i];
            assign npr[LEAVES-1+i] = prio_i[i*PRIO_W +: PRIO_W];
            assign nix[LEAVES-1+i] = IDX_W'(i);
         end else begin : g_pad
            assign nv[LEAVES-1+i]  = 1'b0;
            assign npr[LEAVES-1+i] = '0;
            assign nix[LEAVES-1+i] = '0;
         end
      end

      // left child covers lower indices; right child wins ties
      for (genvar k = 0; k < LEAVES-1; k++) begin : g_node
         logic take_hi;
         assign take_hi = nv[2*k+2] &&
                          (!nv[2*k+1] || (npr[2*k+2] <= npr[2*k+1]));
         assign nv[k]  = nv[2*k+1] | nv[2*k+2];
         assign npr[k] = take_hi ? npr[2*k+2] : npr[2*k+1];
         assign nix[k] = take_hi ? nix[2*k+2] : nix[2*k+1];
      end
   endgenerate

   assign any_o = nv[0];
   assign idx_o = nv[0] ? nix[0] : '0;

   always_comb begin
      // R1
      if (any_o) win_is_cand_chk: assert (valid_i[idx_o]);
   end
endmodule

// File: rtl/arb_path_ctrl.sv
module arb_path_ctrl #(
   parameter int CODE_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rearm_i,
   input  logic              hit_i,
   input  logic [CODE_W-1:0] win_i,
   output logic              req_o,
   output logic [CODE_W-1:0] code_o
);
   logic armed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b1;
         req_o   <= 1'b0;
         code_o  <= '0;
      end else if (rearm_i || armed_q) begin
         if (hit_i) begin
            req_o   <= 1'b1;
            code_o  <= win_i;
            armed_q <= 1'b0;
         end else begin
            armed_q <= 1'b1;
            if (rearm_i) req_o <= 1'b0;
         end
      end
   end

   // R10
   req_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(req_o) |-> $past(hit_i));
   // R7
   drop_on_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rearm_i && !hit_i) |=> !req_o);
   // R5
   hold_latched_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!rearm_i && req_o) |=> (req_o && $stable(code_o)));
   // R10
   code_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(code_o) |-> (req_o && $past(hit_i)));
endmodule

// File: rtl/dual_path_irq_arbiter.sv
module dual_path_irq_arbiter #(
   parameter int NUM_BANKS = 1,
   parameter int PRIO_W    = 5
) (
   input  logic                                            clk,
   input  logic                                            rst_n,
   input  logic [NUM_BANKS*arb_pkg::LINES_PER_BANK-1:0]        pend_i,
   input  logic [NUM_BANKS*arb_pkg::LINES_PER_BANK-1:0]        mask_i,
   input  logic [NUM_BANKS*arb_pkg::LINES_PER_BANK-1:0]        steer_i,
   input  logic [NUM_BANKS*arb_pkg::LINES_PER_BANK*PRIO_W-1:0] prio_i,
   input  logic                                            gen_en_i,
   input  logic                                            rearm_norm_i,
   input  logic                                            rearm_fast_i,
   output logic                                            req_norm_o,
   output logic                                            req_fast_o,
   output logic [$clog2(NUM_BANKS*arb_pkg::LINES_PER_BANK)-1:0] code_norm_o,
   output logic [$clog2(NUM_BANKS*arb_pkg::LINES_PER_BANK)-1:0] code_fast_o
);
   localparam int NUM_LINES = NUM_BANKS * arb_pkg::LINES_PER_BANK;
   localparam int CODE_W    = $clog2(NUM_LINES);

   generate
      if (NUM_BANKS < 1 || NUM_BANKS > arb_pkg::MAX_BANKS) begin : g_bad_banks
         $error("NUM_BANKS must lie in 1..3");
      end
      if (PRIO_W != 5 && PRIO_W != 6) begin : g_bad_prio
         $error("PRIO_W must be 5 or 6");
      end
   endgenerate

   logic [NUM_LINES-1:0] cand  [2];
   logic                 any   [2];
   logic [CODE_W-1:0]    win   [2];
   logic                 req   [2];
   logic [CODE_W-1:0]    code  [2];
   logic                 rearm [2];

   assign rearm[0] = rearm_norm_i;
   assign rearm[1] = rearm_fast_i;

   generate
      for (genvar p = 0; p < 2; p++) begin : g_path
         arb_cand_sel #(
            .NUM_LINES (NUM_LINES),
            .PATH      (arb_pkg::path_e'(p))
         ) u_cand (
            .pend_i  (pend_i),
            .mask_i  (mask_i),
            .steer_i (steer_i),
            .cand_o  (cand[p])
         );

         arb_prio_tree #(
            .NUM_LINES (NUM_LINES),
            .PRIO_W    (PRIO_W)
         ) u_tree (
            .valid_i (cand[p]),
            .prio_i  (prio_i),
            .any_o   (any[p]),
            .idx_o   (win[p])
         );

         arb_path_ctrl #(
            .CODE_W (CODE_W)
         ) u_ctrl (
            .clk     (clk),
            .rst_n   (rst_n),
            .rearm_i (rearm[p]),
            .hit_i   (any[p] && gen_en_i),
            .win_i   (win[p]),
            .req_o   (req[p]),
            .code_o  (code[p])
         );
      end
   endgenerate

   assign req_norm_o  = req[0];
   assign req_fast_o  = req[1];
   assign code_norm_o = code[0];
   assign code_fast_o = code[1];

   always_comb begin
      // R1
      path_excl_chk: assert ((cand[0] & cand[1]) == '0);
   end

   // R6
   no_req_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!gen_en_i && !req_norm_o) |=> !req_norm_o);
endmodule

// File: tb/dual_path_irq_arbiter_bench.sv
`timescale 1ns/1ps
module dual_path_irq_arbiter_bench;
   localparam int NB = 2;
   localparam int PW = 5;
   localparam int NL = NB * 32;
   localparam int CW = $clog2(NL);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NL-1:0]    pend = '0, mask = '1, steer = '0;
   logic [NL*PW-1:0] prio = '0;
   logic en = 1'b1, rn = 1'b0, rf = 1'b0;
   logic req_n, req_f;
   logic [CW-1:0] code_n, code_f;

   int checks = 0, errors = 0;
   bit done = 1'b0;
   int m_req [2], m_code [2], m_arm [2];

   always #2 clk = ~clk;

   dual_path_irq_arbiter #(.NUM_BANKS(NB), .PRIO_W(PW)) u_dual_path_irq_arbiter (
      .clk(clk), .rst_n(rst_n), .pend_i(pend), .mask_i(mask), .steer_i(steer),
      .prio_i(prio), .gen_en_i(en), .rearm_norm_i(rn), .rearm_fast_i(rf),
      .req_norm_o(req_n), .req_fast_o(req_f),
      .code_norm_o(code_n), .code_fast_o(code_f));

   task automatic chk(input string tag, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   task automatic model_path(input int p, input bit strobe);
      bit found = 0;
      int best = 0, w = 0;
      for (int i = 0; i < NL; i++) begin
         int pv;
         pv = int'(prio[i*PW +: PW]);
         if (pend[i] && !mask[i] && (int'(steer[i]) == p)) begin
            if (!found || pv <= best) begin
               found = 1; best = pv; w = i;
            end
         end
      end
      if (strobe) begin
         m_req[p] = 0; m_arm[p] = 1;
      end
      if (m_arm[p] != 0 && found && en) begin
         m_req[p] = 1; m_code[p] = w; m_arm[p] = 0;
      end
   endtask

   task automatic compare(input string tag);
      chk(tag, "req_norm",  int'(req_n),  m_req[0]);
      chk(tag, "code_norm", int'(code_n), m_code[0]);
      chk(tag, "req_fast",  int'(req_f),  m_req[1]);
      chk(tag, "code_fast", int'(code_f), m_code[1]);
   endtask

   task automatic step(input string tag);
      @(posedge clk);
      model_path(0, rn);
      model_path(1, rf);
      #1;
      compare(tag);
      rn = 1'b0;
      rf = 1'b0;
   endtask

   task automatic set_line(input int i, input int pv, input bit fast);
      pend[i] = 1'b1;
      mask[i] = 1'b0;
      steer[i] = fast;
      prio[i*PW +: PW] = PW'(pv);
   endtask

   initial begin
      #(200000 * 4);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      for (int p = 0; p < 2; p++) begin
         m_req[p] = 0; m_code[p] = 0; m_arm[p] = 1;
      end
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      compare("R9");

      pend[5] = 1'b1;                       step("R1");
      mask[5] = 1'b0; prio[5*PW +: PW] = 3; step("R10");
      set_line(9, 1, 1'b0);                 step("R5");
      rn = 1'b1;                            step("R8");
      pend = '0; rn = 1'b1;                 step("R7");
      set_line(3, 2, 1'b0);
      set_line(40, 2, 1'b0);                step("R3");
      set_line(33, 0, 1'b1);                step("R11");
      en = 1'b0; rf = 1'b1;                 step("R6");
                                            step("R6");
      en = 1'b1;                            step("R10");
      prio[3*PW +: PW] = 1; rn = 1'b1;      step("R2");
      steer[33] = 1'b0; rf = 1'b1;          step("R1");
      rn = 1'b1;                            step("R4");

      for (int c = 0; c < 400; c++) begin
         for (int i = 0; i < NL; i++) begin
            pend[i]  = ($urandom % 3) != 0;
            mask[i]  = ($urandom % 4) == 0;
            steer[i] = ($urandom % 2) == 1;
            prio[i*PW +: PW] = PW'($urandom % 4);
         end
         en = ($urandom % 8) != 0;
         rn = ($urandom % 3) == 0;
         rf = ($urandom % 3) == 0;
         step("R2/R3");
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule